// File: doc/BRIEF.md
# Aligned Burst Receive DMA Engine

This block sits beside a byte-wide serial receiver and moves a block of received bytes into memory with no processor help. Software first writes a start address and a byte count into the engine. It then writes the control word with the go bit, the DMA-select bit and the receive direction all set. The engine pulls bytes from the serial side and packs them, most significant byte first, into a 32-byte staging buffer. It then writes the buffer out as eight consecutive 32-bit words through a word-wide write master that uses a valid/ready handshake.

The go bit reads back as busy for the whole transfer and drops in the cycle after the final word of the final burst is accepted. That drop is the only sign that the transfer is complete. The address and the count must both be whole multiples of 32 bytes. A request that breaks this rule, or asks for zero bytes, does not run: it raises a sticky error flag instead.

Top module: `dma_rx_engine`

## Requirements
- R1: After reset, `xfer_busy`, `xfer_err`, `mem_valid` and `ser_ready` are all 0.
- R2: Registers are written through `cfg_we` with a byte offset on `cfg_addr`: 0x04 sets the start address, 0x08 sets the byte count and 0x0C is the control word. In the control word, bit 0 is go, bit 1 is DMA select and bits 3:2 are direction, where 00 means receive. A control write with bits 0 and 1 set and bits 3:2 at 00 starts a transfer when the programmed address and count are valid. From the next cycle `xfer_busy` is 1. It stays 1 until the last word is accepted and is 0 in the cycle after that.
- R3: Received bytes are packed big-endian. The first byte of each group of four lands in bits 31:24 of its word, and the fourth byte lands in bits 7:0.
- R4: A transfer of N bytes produces exactly N/4 memory writes. Their addresses run upward in steps of 4 from the programmed start address, and each 32-byte burst follows the previous one directly.
- R5: A start request is refused if the address has a nonzero value in bits 4:0, if the count has a nonzero value in bits 4:0, or if the count is zero. A refused request sets `xfer_err` and leaves `xfer_busy` at 0. No memory write occurs and no serial byte is taken.
- R6: `xfer_err` stays set until reset or until a later start request is accepted; an accepted request clears it.
- R7: A control write whose DMA-select bit is clear, or whose direction is not 00, neither starts a transfer nor changes `xfer_err`.
- R8: While `xfer_busy` is 1, writes to all three registers are ignored. The running transfer keeps its address and count, and the stored address and count keep their programmed values.
- R9: `ser_ready` is 0 while the engine is idle and while a full burst waits to be written. Serial reception is therefore stalled whenever `mem_valid` is 1.
- R10: While `mem_valid` is 1 and `mem_ready` is 0, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R11: A single transfer of 4096 bytes completes correctly with the default parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 5 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| xfer_busy | output | 1 | Go bit readback; clears on completion |
| xfer_err | output | 1 | Sticky misalignment/zero-count error |
| ser_valid | input | 1 | Serial byte available |
| ser_data | input | 8 | Serial byte |
| ser_ready | output | 1 | Engine accepts a byte this cycle |
| mem_valid | output | 1 | Memory word write request |
| mem_addr | output | AW (32) | Byte address of the word |
| mem_data | output | 32 | Word to write |
| mem_ready | input | 1 | Memory accepts the word |

## Verification
Some internal faults show up on the memory port within the same burst. A slip in the byte-lane index garbles `mem_data` on the first word written. A wrong drain index or current address makes `mem_addr` break the expected stride at once. A wrong remaining-count update is seen only at the end of the transfer: either `xfer_busy` drops before N/4 writes have happened, or it stays high and extra writes appear. A broken stall shows up as `ser_ready` high while a word is pending, so the bench runs memory with gaps in `mem_ready` to hold bursts pending over many cycles.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
    localparam logic [4:0] OFS_ADDR = 5'h04;
    localparam logic [4:0] OFS_LEN  = 5'h08;
    localparam logic [4:0] OFS_CTRL = 5'h0C;
    localparam int unsigned CTL_GO  = 0;
    localparam int unsigned CTL_DMA = 1;
    localparam logic [1:0]  DIR_RX  = 2'b00;
endpackage

// File: rtl/dma_rx_buf.sv
module dma_rx_buf #(
    parameter int unsigned WORDS = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     in_valid,
    input  logic [7:0]               in_data,
    output logic                     in_ready,
    input  logic                     out_ack,
    output logic                     out_valid,
    output logic [31:0]              out_word,
    output logic [$clog2(WORDS)-1:0] out_idx,
    output logic                     out_last
);
    localparam int unsigned NBYTES = WORDS * 4;
    localparam int unsigned CW     = $clog2(NBYTES);
    localparam int unsigned IW     = $clog2(WORDS);

    typedef struct packed {
        logic [WORDS-1:0][31:0] words;
        logic [CW-1:0]          fill;
        logic                   full;
        logic [IW-1:0]          drain;
    } buf_t;

    buf_t buf_d, buf_q;
    logic [1:0] lane_r;

    always_comb begin
        buf_d    = buf_q;
        in_ready = enable && !buf_q.full;
        lane_r   = 2'd3 - buf_q.fill[1:0];
        if (in_valid && in_ready) begin
            buf_d.words[buf_q.fill[CW-1:2]][{lane_r, 3'b000} +: 8] = in_data;
            buf_d.fill = buf_q.fill + 1'b1;
            if (buf_q.fill == CW'(NBYTES - 1)) buf_d.full = 1'b1;
        end
        if (out_ack && buf_q.full) begin
            if (buf_q.drain == IW'(WORDS - 1)) begin
                buf_d.drain = '0;
                buf_d.full  = 1'b0;
            end else begin
                buf_d.drain = buf_q.drain + 1'b1;
            end
        end
        if (!enable) begin
            buf_d.fill  = '0;
            buf_d.full  = 1'b0;
            buf_d.drain = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign out_valid = buf_q.full;
    assign out_word  = buf_q.words[buf_q.drain];
    assign out_idx   = buf_q.drain;
    assign out_last  = (buf_q.drain == IW'(WORDS - 1));

    assert_full_after_last_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && in_valid && in_ready && buf_q.fill == CW'(NBYTES - 1)) |=> out_valid);
endmodule

// File: rtl/dma_rx_ctrl.sv
module dma_rx_ctrl
    import dma_rx_pkg::*;
#(
    parameter int unsigned AW    = 32,
    parameter int unsigned LW    = 16,
    parameter int unsigned BURST = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [4:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    input  logic          burst_done,
    output logic          busy,
    output logic          err,
    output logic [AW-1:0] cur_addr
);
    localparam int unsigned OW = $clog2(BURST);

    typedef struct packed {
        logic [AW-1:0] base;
        logic [LW-1:0] len;
        logic [AW-1:0] cur;
        logic [LW-1:0] rem;
        logic          go;
        logic          err;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic req_rx, ok_cfg;
    logic unused_cfg;
    assign unused_cfg = ^cfg_wdata;

    always_comb begin
        ctl_d  = ctl_q;
        req_rx = cfg_wdata[CTL_GO] && cfg_wdata[CTL_DMA] && (cfg_wdata[3:2] == DIR_RX);
        ok_cfg = (ctl_q.base[OW-1:0] == '0) && (ctl_q.len[OW-1:0] == '0) && (ctl_q.len != '0);
        if (cfg_we && !ctl_q.go) begin
            unique case (cfg_addr)
                OFS_ADDR: ctl_d.base = cfg_wdata[AW-1:0];
                OFS_LEN:  ctl_d.len  = cfg_wdata[LW-1:0];
                OFS_CTRL: if (req_rx) begin
                    if (ok_cfg) begin
                        ctl_d.go  = 1'b1;
                        ctl_d.err = 1'b0;
                        ctl_d.cur = ctl_q.base;
                        ctl_d.rem = ctl_q.len;
                    end else begin
                        ctl_d.err = 1'b1;
                    end
                end
                default: ;
            endcase
        end
        if (ctl_q.go && burst_done) begin
            ctl_d.cur = ctl_q.cur + AW'(BURST);
            ctl_d.rem = ctl_q.rem - LW'(BURST);
            if (ctl_q.rem == LW'(BURST)) ctl_d.go = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign busy     = ctl_q.go;
    assign err      = ctl_q.err;
    assign cur_addr = ctl_q.cur;

    assert_done_on_last_burst_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ctl_q.go) |-> $past(burst_done));
    assert_running_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.go |-> (ctl_q.cur[OW-1:0] == '0 && ctl_q.rem != '0));
    assert_error_never_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_q.err) |-> !ctl_q.go);
endmodule

// File: rtl/dma_rx_engine.sv
module dma_rx_engine #(
    parameter int unsigned AW    = 32,
    parameter int unsigned LW    = 16,
    parameter int unsigned BURST = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [4:0]    cfg_addr,
    input  logic [31:0]   cfg_wdata,
    output logic          xfer_busy,
    output logic          xfer_err,
    input  logic          ser_valid,
    input  logic [7:0]    ser_data,
    output logic          ser_ready,
    output logic          mem_valid,
    output logic [AW-1:0] mem_addr,
    output logic [31:0]   mem_data,
    input  logic          mem_ready
);
    localparam int unsigned WORDS = BURST / 4;
    localparam int unsigned IW    = $clog2(WORDS);

    logic          pend, last, ack, burst_done;
    logic [IW-1:0] idx;
    logic [AW-1:0] cur;

    dma_rx_ctrl #(.AW(AW), .LW(LW), .BURST(BURST)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .burst_done(burst_done),
        .busy(xfer_busy), .err(xfer_err), .cur_addr(cur)
    );

    dma_rx_buf #(.WORDS(WORDS)) u_buf (
        .clk(clk), .rst_n(rst_n), .enable(xfer_busy),
        .in_valid(ser_valid), .in_data(ser_data), .in_ready(ser_ready),
        .out_ack(ack), .out_valid(pend), .out_word(mem_data),
        .out_idx(idx), .out_last(last)
    );

    assign mem_valid  = xfer_busy && pend;
    assign ack        = mem_valid && mem_ready;
    assign burst_done = ack && last;
    assign mem_addr   = cur + (AW'(idx) << 2);

    assert_stall_while_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> !ser_ready);
    assert_hold_until_ready_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data)));
endmodule

// File: tb/tb_dma_rx_engine.sv
module tb_dma_rx_engine;
    logic        clk = 0, rst_n = 0;
    logic        cfg_we = 0;
    logic [4:0]  cfg_addr = 0;
    logic [31:0] cfg_wdata = 0;
    logic        xfer_busy, xfer_err, ser_ready, mem_valid;
    logic        ser_valid = 0;
    logic [7:0]  ser_data = 0;
    logic [31:0] mem_addr, mem_data;
    logic        mem_ready = 0;

    always #5 clk = ~clk;

    dma_rx_engine dut (.*);

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [31:0] exp_base;
    logic [7:0]  exp_seed;
    int wr_count = 0, bad_addr = 0, bad_data = 0, stall_bad = 0, ready_mode = 0, cyc = 0;

    // base, length, seed, ready mode (0 always, 1 every third cycle, 2 every other)
    localparam logic [63:0] VEC [4] = '{
        {32'h0000_0100, 16'd32,   8'h10, 8'd0},
        {32'h0000_0400, 16'd96,   8'hA5, 8'd1},
        {32'h0000_2000, 16'd4096, 8'h3C, 8'd0},
        {32'h0000_1FE0, 16'd64,   8'h77, 8'd2}
    };

    function automatic logic [7:0] byte_at(logic [7:0] seed, int j);
        return seed + 8'(j * 3);
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        case (ready_mode)
            1: mem_ready = (cyc % 3 == 0);
            2: mem_ready = cyc[0];
            default: mem_ready = 1'b1;
        endcase
        if (mem_valid && ser_ready) stall_bad++;
        if (mem_valid && mem_ready) begin
            if (mem_addr !== exp_base + 32'(wr_count * 4)) bad_addr++;
            if (mem_data !== {byte_at(exp_seed, 4*wr_count), byte_at(exp_seed, 4*wr_count+1),
                              byte_at(exp_seed, 4*wr_count+2), byte_at(exp_seed, 4*wr_count+3)})
                bad_data++;
            wr_count++;
        end
    end

    task automatic cfg_write(logic [4:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic send_bytes(logic [7:0] seed, int n);
        for (int j = 0; j < n; j++) begin
            @(negedge clk);
            ser_valid = 1; ser_data = byte_at(seed, j);
            while (!ser_ready) @(negedge clk);
            @(posedge clk); #1;
            ser_valid = 0;
        end
    endtask

    task automatic arm(logic [31:0] base, logic [7:0] seed);
        exp_base = base; exp_seed = seed;
        wr_count = 0; bad_addr = 0; bad_data = 0;
    endtask

    task automatic finish_xfer(string req, int len);
        while (xfer_busy) @(negedge clk);
        check({req, " write count"}, 32'(wr_count), 32'(len / 4));
        check("R4 address sequence", 32'(bad_addr), 0);
        check("R3 big-endian data", 32'(bad_data), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 busy", 32'(xfer_busy), 0);
        check("R1 err", 32'(xfer_err), 0);
        check("R1 mem_valid", 32'(mem_valid), 0);
        check("R1 ser_ready", 32'(ser_ready), 0);
        rst_n = 1;
        @(negedge clk);

        for (int v = 0; v < 4; v++) begin
            ready_mode = int'(VEC[v][7:0]);
            arm(VEC[v][63:32], VEC[v][15:8]);
            cfg_write(5'h04, VEC[v][63:32]);
            cfg_write(5'h08, 32'(VEC[v][31:16]));
            cfg_write(5'h0C, 32'h3);
            check("R2 busy after start", 32'(xfer_busy), 1);
            send_bytes(VEC[v][15:8], int'(VEC[v][31:16]));
            finish_xfer(VEC[v][31:16] == 16'd4096 ? "R11" : "R2", int'(VEC[v][31:16]));
        end
        check("R9 ser_ready low while word pending", 32'(stall_bad), 0);
        ready_mode = 0;

        // R5 misaligned address
        arm(32'h0, 8'h0);
        cfg_write(5'h04, 32'h0000_0110);
        cfg_write(5'h08, 32'd64);
        cfg_write(5'h0C, 32'h3);
        check("R5 misaligned address err", 32'(xfer_err), 1);
        check("R5 misaligned address busy", 32'(xfer_busy), 0);
        @(negedge clk);
        check("R5 ser_ready idle", 32'(ser_ready), 0);
        repeat (10) @(negedge clk);
        check("R6 err sticky", 32'(xfer_err), 1);
        check("R5 no memory write", 32'(wr_count), 0);

        // R7 control words that do not request receive DMA
        cfg_write(5'h0C, 32'h1);
        check("R7 no DMA bit busy", 32'(xfer_busy), 0);
        check("R7 no DMA bit err unchanged", 32'(xfer_err), 1);

        // R6 accepted start clears err
        arm(32'h0000_0600, 8'h51);
        cfg_write(5'h04, 32'h0000_0600);
        cfg_write(5'h0C, 32'h3);
        check("R6 err cleared by accepted start", 32'(xfer_err), 0);
        check("R6 busy after accepted start", 32'(xfer_busy), 1);
        // R8 register writes during a transfer are ignored
        fork
            send_bytes(8'h51, 64);
            begin
                repeat (20) @(negedge clk);
                cfg_write(5'h04, 32'h0000_0900);
                cfg_write(5'h08, 32'd32);
                cfg_write(5'h0C, 32'h3);
            end
        join
        finish_xfer("R8", 64);
        // stored address and count unchanged: restart reuses 0x600 and 64
        arm(32'h0000_0600, 8'h22);
        cfg_write(5'h0C, 32'h3);
        send_bytes(8'h22, 64);
        finish_xfer("R8 stored count", 64);

        cfg_write(5'h0C, 32'h7);
        check("R7 write direction busy", 32'(xfer_busy), 0);
        check("R7 write direction err", 32'(xfer_err), 0);
        @(negedge clk);
        check("R7 ser_ready stays low", 32'(ser_ready), 0);

        // R5 zero length and misaligned length
        cfg_write(5'h08, 32'd0);
        cfg_write(5'h0C, 32'h3);
        check("R5 zero length err", 32'(xfer_err), 1);
        check("R5 zero length busy", 32'(xfer_busy), 0);
        cfg_write(5'h08, 32'd32);
        cfg_write(5'h0C, 32'h3);
        check("R6 cleared again", 32'(xfer_err), 0);
        send_bytes(8'h01, 32);
        while (xfer_busy) @(negedge clk);
        wr_count = 0;
        cfg_write(5'h08, 32'd40);
        cfg_write(5'h0C, 32'h3);
        check("R5 misaligned length err", 32'(xfer_err), 1);
        check("R5 misaligned length busy", 32'(xfer_busy), 0);
        repeat (5) @(negedge clk);
        check("R5 no write on misaligned length", 32'(wr_count), 0);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule